// File: doc/BRIEF.md
# Ramped Stereo Attenuator with Soft Mute

This block scales a stream of stereo 16-bit two's-complement samples by a single gain shared by both channels. The gain is a 7-bit counter value `g`, and each output equals `sample * g / 127`. The division is exact and rounds toward zero, so `g = 127` passes samples through unchanged and `g = 0` gives silence.

The counter never jumps. It moves one unit toward an effective target after every eight accepted samples. The effective target is the `target_gain` input. While `mute_req` is high, the effective target is zero instead. A soft mute is therefore a ramp down that takes at most 127 steps, and releasing the mute ramps the gain back up at the same rate. The block sits between a control block that supplies the attenuation setting and the downstream filters that consume the scaled samples. Its only handshake is a one-cycle sample strobe.

Top module: `ramp_gain_atten`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_valid` is high and each output equals the matching input sample times the `gain_now` value of the input cycle, divided by 127 and truncated toward zero. In any other cycle `out_valid` is low.
- R2: While `gain_now` is 127, each output equals its input bit for bit, including -32768 and 32767.
- R3: While `gain_now` is 0, both outputs are 0 for any input.
- R4: The left and right samples of one strobe are scaled by the same `gain_now` value.
- R5: From one clock to the next, `gain_now` changes by at most 1. Any change is toward the effective target and never passes it.
- R6: A step happens on the edge of the 8th strobed sample counted since the window began. Cycles with `in_valid` low neither advance the count nor change the gain.
- R7: The sample count is cleared in every cycle where `gain_now` equals the effective target. After the target moves away, the first step therefore needs a full 8 strobed samples.
- R8: While `mute_req` is high, the effective target is 0 whatever `target_gain` holds. Releasing the mute ramps the gain to `target_gain` at one step per 8 samples.
- R9: If the target moves to the other side of `gain_now` in mid-window, the next step goes the new way. The window count is kept, and the gain does not overshoot.
- R10: During reset (`rst` high at a clock edge), `gain_now` becomes 0, `out_valid` becomes 0 and both outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: a stereo sample is present |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| target_gain | input | 7 | Requested gain, 0 to 127 |
| mute_req | input | 1 | Soft-mute request, forces the target to 0 |
| out_valid | output | 1 | Strobe for the scaled outputs |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| gain_now | output | 7 | Current gain counter value |

## Verification
Scaling and stepping can fall on the same edge. The 8th sample of a window is scaled with the gain from before the step, while the counter moves on that same edge. A bench model updates its gain only after it has computed that sample's expected output, so any early use of the new gain shows up as a value mismatch. The bench also changes the target and raises the mute on a window's final sample and in mid-window. It then compares `gain_now` with the model after every sample and every idle cycle.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int GAIN_W    = 7;
    localparam int NUM_CH    = 2;
    localparam int GAIN_FULL = (1 << GAIN_W) - 1;
    localparam int PROD_W    = SAMPLE_W + GAIN_W + 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic        [GAIN_W-1:0]   gain_t;
    typedef logic        [SAMPLE_W:0]   mag_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    // Direction in which the counter has to travel to meet its goal.
    function automatic step_dir_e step_dir(gain_t cur, gain_t goal);
        if (cur < goal)      return STEP_UP;
        else if (cur > goal) return STEP_DOWN;
        else                 return STEP_HOLD;
    endfunction

    // Exact sample * g / GAIN_FULL, truncated toward zero.
    function automatic sample_t scale_sample(sample_t s, gain_t g);
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] quot;
        prod = $signed(s) * $signed({1'b0, g});
        quot = prod / $signed(PROD_W'(GAIN_FULL));
        return quot[SAMPLE_W-1:0];
    endfunction

    // Absolute value, one bit wider so that the most negative code fits.
    function automatic mag_t magnitude(sample_t s);
        logic signed [SAMPLE_W:0] w;
        w = {s[SAMPLE_W-1], s};
        return (w < 0) ? mag_t'(-w) : mag_t'(w);
    endfunction

endpackage

// File: rtl/atten_target_sel.sv
module atten_target_sel
    import atten_pkg::*;
(
    input  gain_t target_gain,
    input  logic  mute_req,
    output gain_t eff_target
);
    always_comb begin
        eff_target = mute_req ? gain_t'(0) : target_gain;
    end
endmodule

// File: rtl/atten_gain_ctrl.sv
module atten_gain_ctrl
    import atten_pkg::*;
#(
    parameter int STEP_SAMPLES = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  gain_t goal,
    output gain_t gain_q
);
    localparam int TMR_W = (STEP_SAMPLES > 1) ? $clog2(STEP_SAMPLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_SAMPLES - 1);

    logic [TMR_W-1:0] timer_q;
    step_dir_e        dir;

    always_comb begin
        dir = step_dir(gain_q, goal);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q  <= '0;
            timer_q <= '0;
        end else if (dir == STEP_HOLD) begin
            timer_q <= '0;
        end else if (valid) begin
            if (timer_q == TMR_LAST) begin
                timer_q <= '0;
                if (dir == STEP_UP) gain_q <= gain_q + gain_t'(1);
                else                gain_q <= gain_q - gain_t'(1);
            end else begin
                timer_q <= timer_q + TMR_W'(1);
            end
        end
    end

    // R5 R9
    toward_goal_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gain_q == $past(gain_q)) ||
                  (({1'b0, gain_q} == {1'b0, $past(gain_q)} + 8'd1) && ($past(gain_q) < $past(goal))) ||
                  (({1'b0, gain_q} + 8'd1 == {1'b0, $past(gain_q)}) && ($past(gain_q) > $past(goal)))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(gain_q));

    // R7
    window_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_q == goal) |=> (timer_q == '0));

endmodule

// File: rtl/atten_scaler.sv
module atten_scaler
    import atten_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_sample,
    input  gain_t   gain,
    output sample_t out_sample
);
    always_ff @(posedge clk) begin
        if (rst)           out_sample <= '0;
        else if (in_valid) out_sample <= scale_sample(in_sample, gain);
    end

    // R2
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gain == gain_t'(GAIN_FULL)) |=> (out_sample == $past(in_sample)));

    // R3
    silence_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gain == '0) |=> (out_sample == '0));

    // R1
    no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (magnitude(out_sample) <= magnitude($past(in_sample))));

endmodule

// File: rtl/ramp_gain_atten.sv
module ramp_gain_atten
    import atten_pkg::*;
#(
    parameter int STEP_SAMPLES = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic        [GAIN_W-1:0]   target_gain,
    input  logic                       mute_req,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic        [GAIN_W-1:0]   gain_now
);
    gain_t   eff_target;
    gain_t   gain_q;
    sample_t ch_in  [NUM_CH];
    sample_t ch_out [NUM_CH];

    atten_target_sel u_tsel (
        .target_gain (target_gain),
        .mute_req    (mute_req),
        .eff_target  (eff_target)
    );

    atten_gain_ctrl #(.STEP_SAMPLES(STEP_SAMPLES)) u_gctl (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .goal   (eff_target),
        .gain_q (gain_q)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    // R4: every channel sees the one shared counter value
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        atten_scaler u_scl (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid),
            .in_sample  (ch_in[c]),
            .gain       (gain_q),
            .out_sample (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];
    assign gain_now  = gain_q;

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R8
    mute_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (mute_req && gain_now == '0) |=> (gain_now == '0));

endmodule

// File: tb/sim_ramp_gain_atten.sv
module sim_ramp_gain_atten;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_left = '0, in_right = '0;
    logic [6:0] target_gain = '0;
    logic mute_req = 1'b0;
    logic out_valid;
    logic signed [15:0] out_left, out_right;
    logic [6:0] gain_now;

    int n_tests = 0, n_fail = 0;
    int mg = 0, mt = 0;
    int seq = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_gain_atten u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .target_gain(target_gain), .mute_req(mute_req),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .gain_now(gain_now)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_t();
        return mute_req ? 0 : int'(target_gain);
    endfunction

    // Model update for one edge; v tells whether a sample was strobed.
    task automatic model_edge(bit v);
        int t = eff_t();
        if (mg == t) mt = 0;
        else if (v) begin
            if (mt == STEP - 1) begin
                mg = (mg < t) ? mg + 1 : mg - 1;
                mt = 0;
            end else mt++;
        end
    endtask

    task automatic send(int l, int r);
        int el, er;
        in_valid = 1'b1;
        in_left  = 16'(l);
        in_right = 16'(r);
        el = (l * mg) / 127;
        er = (r * mg) / 127;
        model_edge(1'b1);
        @(negedge clk);
        check(out_valid == 1'b1, "R1 valid", int'(out_valid), 1);
        check(int'(out_left) == el, "R1 left", int'(out_left), el);
        check(int'(out_right) == er, "R4 right", int'(out_right), er);
        check(int'(gain_now) == mg, "R5 gain", int'(gain_now), mg);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        model_edge(1'b0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);
        check(int'(gain_now) == mg, "R6 idle gain", int'(gain_now), mg);
    endtask

    task automatic pat(int n);
        for (int i = 0; i < n; i++) begin
            int l, r;
            seq++;
            if (seq % 64 == 0) begin l = -32768; r = 32767; end
            else begin
                l = ((seq * 7919) % 65536) - 32768;
                r = 32767 - ((seq * 104729) % 65536);
            end
            send(l, r);
            if (seq % 37 == 0) idle();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 valid", int'(out_valid), 0);
        check(gain_now == 7'd0, "R10 gain", int'(gain_now), 0);
        check(out_left == 16'sd0 && out_right == 16'sd0, "R10 data", int'(out_left), 0);
        rst = 1'b0;
        @(negedge clk);

        // silence at gain 0
        send(32767, -32768);
        check(out_left == 16'sd0 && out_right == 16'sd0, "R3 zero gain", int'(out_left), 0);

        // full ramp up from 0
        target_gain = 7'd127;
        pat(127 * STEP + 4);
        check(gain_now == 7'd127, "R5 top reached", int'(gain_now), 127);
        send(-32768, 32767);
        check(out_left == -16'sd32768 && out_right == 16'sd32767, "R2 unity", int'(out_left), -32768);
        send(12345, -1);
        check(out_left == 16'sd12345 && out_right == -16'sd1, "R2 unity mid", int'(out_left), 12345);

        // step timing with idles inside the window
        target_gain = 7'd126;
        pat(3); idle(); idle(); pat(4);
        check(gain_now == 7'd127, "R6 seven samples", int'(gain_now), 127);
        pat(1);
        check(gain_now == 7'd126, "R6 eighth sample", int'(gain_now), 126);

        // window restarts after resting on target
        pat(5);
        target_gain = 7'd125;
        pat(7);
        check(gain_now == 7'd126, "R7 fresh window", int'(gain_now), 126);
        pat(1);
        check(gain_now == 7'd125, "R7 step", int'(gain_now), 125);

        // reversal in mid-window
        target_gain = 7'd100;
        pat(12);
        check(gain_now == 7'd124, "R9 descending", int'(gain_now), 124);
        target_gain = 7'd127;
        pat(4);
        check(gain_now == 7'd125, "R9 reversed", int'(gain_now), 125);
        pat(2 * STEP + 3);
        check(gain_now == 7'd127, "R9 no overshoot", int'(gain_now), 127);
        pat(STEP + 1);
        check(gain_now == 7'd127, "R9 held", int'(gain_now), 127);

        // soft mute raised on a window boundary sample
        target_gain = 7'd120;
        pat(STEP - 1);
        mute_req = 1'b1;
        pat(127 * STEP + 2);
        check(gain_now == 7'd0, "R8 muted", int'(gain_now), 0);
        target_gain = 7'd50;
        pat(2 * STEP);
        check(gain_now == 7'd0, "R8 target ignored", int'(gain_now), 0);
        send(-32768, 32767);
        check(out_left == 16'sd0 && out_right == 16'sd0, "R3 muted output", int'(out_left), 0);

        // release: back up to 50 at the same rate
        mute_req = 1'b0;
        for (int i = 0; i < 50 * STEP - 1; i++) send(1000 + i, -1000 - i);
        check(gain_now == 7'd49, "R8 release rate", int'(gain_now), 49);
        send(20000, -20000);
        check(gain_now == 7'd50, "R8 release end", int'(gain_now), 50);

        // sweep of sample values at a few gains
        for (int v = -32768; v < 32768; v += 1031) send(v, -v - 1);
        target_gain = 7'd127;
        pat(77 * STEP + 2);
        send(-32768, 32767);
        check(out_left == -16'sd32768, "R2 unity again", int'(out_left), -32768);

        idle();
        finish_run();
    end
endmodule